// File: doc/BRIEF.md
# Gyroscope Serial Register Access Engine

This block is a serial-peripheral master that carries out 32-bit command/response exchanges with a digital rate gyroscope. A host asks for one of three operations: a fetch of the current rate sample, a read of a 16-bit register pair, or a write of a 16-bit register pair. The engine builds the command word, pads it to odd parity through its lowest bit and shifts it out most significant bit first with chip select low. It then releases chip select for a programmable minimum time and clocks a second 32-bit frame. The sensor returns the answer to a command in the frame that follows it, so the engine samples the response there.

From the response frame the engine takes the 16-bit payload, the 2-bit status field and a write-fault flag, and presents them together with a one-cycle completion pulse. After a write it stays busy for a programmable hold time before it takes the next request. The serial clock polarity and phase, the clock divider, the chip-select gap and the write hold are parameters.

Top module: `gyro_spi_engine`

## Requirements
- R1: The command type occupies bits 31:29 of the command word: 3'b001 for a rate fetch, 3'b100 for a register read and 3'b010 for a register write. Request kind encoding: 2'd0 rate fetch, 2'd1 read, 2'd2 write, and 2'd3 is handled as a rate fetch.
- R2: For reads and writes the register address is placed in bits 24:17 with bit 17 forced to 0 (the even register of the pair); a write places its 16-bit value in bits 16:1. All other bits of the command word, and bits 28:1 of a rate fetch, are 0.
- R3: Bit 0 of every command word is set exactly when bits 31:1 hold an even number of ones, so the whole word has odd parity.
- R4: Each frame is 32 serial clock cycles with chip select low throughout, bits sent most significant first; the serial clock rests at the CPOL level whenever chip select is high; the second frame sends all zeros.
- R5: Chip select stays high for at least CS_GAP clock cycles between the command frame and the response frame, and between consecutive transactions.
- R6: For reads and writes the result is response bits 20:5; for a rate fetch it is response bits 25:10. The status output is response bits 27:26, and the write-fault output is set when the request was a write and any of response bits 31:29 is 1.
- R7: Completion is signalled by a pulse on `done` lasting exactly one clock cycle, with the result outputs valid in that cycle and held until the next completion.
- R8: `busy` is high from the cycle after a request is accepted until the engine is idle again; a request presented while busy is ignored and causes no frame.
- R9: After a write completes, `busy` stays high for at least WR_HOLD clock cycles, counting the completion cycle.
- R10: After reset `busy` and `done` are 0, chip select is high and the serial clock is at the CPOL level.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | Operation: 0 rate fetch, 1 read, 2 write, 3 rate fetch |
| req_addr | input | 8 | Register address (bit 0 ignored) |
| req_wdata | input | 16 | Value for a register write |
| busy | output | 1 | Transaction or post-write hold in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Extracted payload |
| rsp_status | output | 2 | Response status field |
| rsp_wr_err | output | 1 | Write fault reported by the sensor |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
The assertions watch, on every cycle, the framing rules: chip select low whenever bits are shifting, the serial clock resting at its idle level outside a frame, the chip-select high time before each frame, the single-cycle completion pulse and the length of the post-write busy window. What only the bench scenarios can show is the content: the exact command word with its type, address, data and parity bits, the zero-filled second frame, and the payload, status and fault fields extracted from the response a sensor model returns. The bench also shows that a request presented mid-transaction produces no extra frame.

// File: rtl/gyro_spi_pkg.sv
package gyro_spi_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 8;

  typedef enum logic [1:0] {
    K_SENSOR = 2'd0,
    K_READ   = 2'd1,
    K_WRITE  = 2'd2,
    K_ALT    = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_GAP, ST_RSP, ST_TAIL
  } eng_state_e;

  // Kind 3 is folded onto the rate fetch.
  function automatic req_kind_e norm_kind(input logic [1:0] k);
    return (k == 2'd3) ? K_SENSOR : req_kind_e'(k);
  endfunction

  // Command word with odd-parity padding in bit 0.
  function automatic logic [FRAME_W-1:0] build_cmd(input req_kind_e k,
                                                   input logic [ADDR_W-1:0] a,
                                                   input logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] w;
    w = '0;
    case (k)
      K_READ: begin
        w[31:29] = 3'b100;
        w[24:17] = {a[ADDR_W-1:1], 1'b0};
      end
      K_WRITE: begin
        w[31:29] = 3'b010;
        w[24:17] = {a[ADDR_W-1:1], 1'b0};
        w[16:1]  = d;
      end
      default: w[31:29] = 3'b001;
    endcase
    w[0] = ~(^w[FRAME_W-1:1]);
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pick_payload(input req_kind_e k,
                                                     input logic [FRAME_W-1:0] r);
    return (k == K_SENSOR) ? r[25:10] : r[20:5];
  endfunction

  function automatic logic [1:0] pick_status(input logic [FRAME_W-1:0] r);
    return r[27:26];
  endfunction

  function automatic logic write_fault(input req_kind_e k,
                                       input logic [FRAME_W-1:0] r);
    return (k == K_WRITE) && (|r[31:29]);
  endfunction
endpackage

// File: rtl/gyro_spi_timer.sv
module gyro_spi_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/gyro_spi_shifter.sv
module gyro_spi_shifter #(
  parameter int FRAME_W = 32,
  parameter int CLK_DIV = 4,
  parameter bit CPOL    = 1'b0,
  parameter bit CPHA    = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               active,
  output logic               fin,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int EDGES  = 2 * FRAME_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int DIV_W  = $clog2(CLK_DIV + 1);

  logic [DIV_W-1:0]   div_q;
  logic [EDGE_W-1:0]  edge_q;
  logic               sclk_q, mosi_q, active_q, fin_q;
  logic [FRAME_W-1:0] tx_q, rx_q;

  // Named edge events of the serial clock.
  logic tick, lead_ev, trail_ev, samp_ev, drive_ev, last_ev;
  assign tick     = active_q && (div_q == DIV_W'(CLK_DIV - 1));
  assign lead_ev  = tick && !edge_q[0];
  assign trail_ev = tick &&  edge_q[0];
  assign last_ev  = tick && (edge_q == EDGE_W'(EDGES - 1));

  generate
    if (CPHA) begin : g_ph1
      assign samp_ev  = trail_ev;
      assign drive_ev = lead_ev;
    end else begin : g_ph0
      assign samp_ev  = lead_ev;
      assign drive_ev = trail_ev;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      edge_q   <= '0;
      sclk_q   <= CPOL;
      mosi_q   <= 1'b0;
      active_q <= 1'b0;
      fin_q    <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start && !active_q) begin
        active_q <= 1'b1;
        div_q    <= '0;
        edge_q   <= '0;
        sclk_q   <= CPOL;
        if (CPHA) begin
          mosi_q <= 1'b0;
          tx_q   <= tx_word;
        end else begin
          mosi_q <= tx_word[FRAME_W-1];
          tx_q   <= tx_word << 1;
        end
      end else if (active_q) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
        end
        if (samp_ev)  rx_q <= {rx_q[FRAME_W-2:0], miso};
        if (drive_ev) begin
          mosi_q <= tx_q[FRAME_W-1];
          tx_q   <= tx_q << 1;
        end
        if (last_ev) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
          edge_q   <= '0;
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign active  = active_q;
  assign fin     = fin_q;
  assign rx_word = rx_q;

  // R4: clock rests at its idle level outside a frame.
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (sclk_q == CPOL));
  // R4: a frame end is only reported by a running shifter.
  a_r4_fin_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> $past(active_q));
endmodule

// File: rtl/gyro_spi_engine.sv
module gyro_spi_engine
  import gyro_spi_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 8,
  parameter int WR_HOLD = 20000,
  parameter bit CPOL    = 1'b0,
  parameter bit CPHA    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rsp_data,
  output logic [1:0]  rsp_status,
  output logic        rsp_wr_err,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HOLD_LEN = (WR_HOLD > CS_GAP) ? WR_HOLD : CS_GAP;
  localparam int CNT_W    = $clog2(HOLD_LEN + 2);

  eng_state_e         st_q, st_d;
  req_kind_e          kind_q;
  logic               cs_n_q, done_q, wr_err_q;
  logic [DATA_W-1:0]  data_q;
  logic [1:0]         status_q;

  logic               sh_start, sh_fin, sh_active;
  logic [FRAME_W-1:0] sh_tx, sh_rx;
  logic               tmr_load, tmr_expired;
  logic [CNT_W-1:0]   tmr_val;

  // Named internal events.
  logic accept_ev, cmd_end_ev, rsp_go_ev, rsp_end_ev;
  assign accept_ev  = (st_q == ST_IDLE) && req_valid;
  assign cmd_end_ev = (st_q == ST_CMD) && sh_fin;
  assign rsp_go_ev  = (st_q == ST_GAP) && tmr_expired;
  assign rsp_end_ev = (st_q == ST_RSP) && sh_fin;

  assign sh_start = accept_ev || rsp_go_ev;
  assign sh_tx    = accept_ev ? build_cmd(norm_kind(req_kind), req_addr, req_wdata)
                              : '0;
  assign tmr_load = cmd_end_ev || rsp_end_ev;
  assign tmr_val  = (rsp_end_ev && kind_q == K_WRITE) ? CNT_W'(HOLD_LEN)
                                                      : CNT_W'(CS_GAP);

  gyro_spi_shifter #(
    .FRAME_W(FRAME_W), .CLK_DIV(CLK_DIV), .CPOL(CPOL), .CPHA(CPHA)
  ) shifter_i (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_word(sh_tx),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .active(sh_active), .fin(sh_fin), .rx_word(sh_rx)
  );

  gyro_spi_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept_ev)   st_d = ST_CMD;
      ST_CMD:  if (sh_fin)      st_d = ST_GAP;
      ST_GAP:  if (tmr_expired) st_d = ST_RSP;
      ST_RSP:  if (sh_fin)      st_d = ST_TAIL;
      ST_TAIL: if (tmr_expired) st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= K_SENSOR;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      data_q   <= '0;
      status_q <= '0;
      wr_err_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_n_q <= !(st_d == ST_CMD || st_d == ST_RSP);
      done_q <= rsp_end_ev;
      if (accept_ev) kind_q <= norm_kind(req_kind);
      if (rsp_end_ev) begin
        data_q   <= pick_payload(kind_q, sh_rx);
        status_q <= pick_status(sh_rx);
        wr_err_q <= write_fault(kind_q, sh_rx);
      end
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign rsp_data   = data_q;
  assign rsp_status = status_q;
  assign rsp_wr_err = wr_err_q;
  assign spi_cs_n   = cs_n_q;

  // ---- checker state for the timing assertions ----
  logic [CNT_W-1:0] hi_run_q, hold_run_q;
  logic             seen_frame_q, wr_tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q     <= '0;
      hold_run_q   <= '0;
      seen_frame_q <= 1'b0;
      wr_tail_q    <= 1'b0;
    end else begin
      if (!spi_cs_n)                          hi_run_q <= '0;
      else if (hi_run_q < CNT_W'(CS_GAP))     hi_run_q <= hi_run_q + 1'b1;
      if (!spi_cs_n) seen_frame_q <= 1'b1;
      if (rsp_end_ev && kind_q == K_WRITE) begin
        wr_tail_q  <= 1'b1;
        hold_run_q <= CNT_W'(1);
      end else if (!busy) begin
        wr_tail_q  <= 1'b0;
      end else if (hold_run_q < CNT_W'(WR_HOLD)) begin
        hold_run_q <= hold_run_q + 1'b1;
      end
    end
  end

  // R5: enough chip-select high time before every frame but the first.
  a_r5_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n) && seen_frame_q) |-> (hi_run_q >= CNT_W'(CS_GAP)));
  // R4: chip select is low whenever bits are shifting.
  a_r4_cs_low_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> !spi_cs_n);
  // R7: completion lasts one cycle.
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: completion is reported while the engine still holds busy.
  a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R9: the post-write window is long enough.
  a_r9_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && wr_tail_q) |-> (hold_run_q >= CNT_W'(WR_HOLD)));
endmodule

// File: tb/gyro_spi_engine_tb_top.sv
`timescale 1ns/1ps
module gyro_spi_engine_tb_top;
  localparam int P_DIV  = 2;
  localparam int P_GAP  = 5;
  localparam int P_HOLD = 300;
  localparam real TCK   = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, rsp_wr_err, spi_cs_n, spi_sclk, spi_mosi;
  logic [15:0] rsp_data;
  logic [1:0]  rsp_status;
  logic        spi_miso;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gyro_spi_engine #(.CLK_DIV(P_DIV), .CS_GAP(P_GAP), .WR_HOLD(P_HOLD),
                    .CPOL(1'b0), .CPHA(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rsp_data(rsp_data), .rsp_status(rsp_status), .rsp_wr_err(rsp_wr_err),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---- sensor model (mode 0 slave) ----
  logic [31:0] slave_resp = '0, sreg = '0, cap = '0;
  logic [31:0] last_cap = '0, prev_cap = '0;
  int   sclk_n = 0, last_sclk_n = 0, prev_sclk_n = 0, frames = 0;
  real  last_rise = -1.0e6, gap_last = 0.0, gap_prev = 0.0;

  assign spi_miso = sreg[31];

  always @(negedge spi_cs_n) begin
    sreg     = slave_resp;
    cap      = '0;
    sclk_n   = 0;
    gap_prev = gap_last;
    gap_last = $realtime - last_rise;
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    prev_cap    = last_cap;
    last_cap    = cap;
    prev_sclk_n = last_sclk_n;
    last_sclk_n = sclk_n;
    last_rise   = $realtime;
    frames++;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cap = {cap[30:0], spi_mosi};
    sclk_n++;
  end
  always @(negedge spi_sclk) if (!spi_cs_n) sreg = sreg << 1;

  // ---- bench reference functions ----
  function automatic logic [31:0] ref_cmd(input logic [1:0] k, input logic [7:0] a,
                                          input logic [15:0] d);
    logic [31:0] w;
    int ones;
    w = 32'h0;
    if (k == 2'd1)      w = 32'h8000_0000 | (32'(a & 8'hFE) << 17);
    else if (k == 2'd2) w = 32'h4000_0000 | (32'(a & 8'hFE) << 17) | (32'(d) << 1);
    else                w = 32'h2000_0000;
    ones = 0;
    for (int i = 0; i < 32; i++) ones += int'(w[i]);
    if (ones % 2 == 0) w = w + 32'd1;
    return w;
  endfunction

  function automatic logic [15:0] ref_data(input logic [1:0] k, input logic [31:0] r);
    if (k == 2'd1 || k == 2'd2) return 16'((r >> 5) & 32'hFFFF);
    return 16'((r >> 10) & 32'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic txn(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d,
                     input logic [31:0] resp, input bit poke);
    int f0, cnt, guard;
    logic [31:0] ecmd;
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    slave_resp = resp;
    f0 = frames;
    ecmd = ref_cmd(k, a, d);
    req_kind = k; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req_kind = 2'd2; req_addr = 8'h3C; req_wdata = 16'hA5A5; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R7 done seen", 32'(done), 32'd1);
    chk(rsp_data == ref_data(k, resp), "R6 payload", 32'(rsp_data), 32'(ref_data(k, resp)));
    chk(rsp_status == resp[27:26], "R6 status", 32'(rsp_status), 32'(resp[27:26]));
    chk(rsp_wr_err == (k == 2'd2 && resp[31:29] != 3'b000), "R6 write fault",
        32'(rsp_wr_err), 32'(k == 2'd2 && resp[31:29] != 3'b000));
    chk(prev_cap[31:29] == ecmd[31:29], "R1 type field", 32'(prev_cap[31:29]), 32'(ecmd[31:29]));
    chk(prev_cap[31:1] == ecmd[31:1], "R2 command body", prev_cap, ecmd);
    chk(^prev_cap == 1'b1 && prev_cap[0] == ecmd[0], "R3 parity", prev_cap, ecmd);
    chk(last_cap == 32'h0, "R4 zero response frame", last_cap, 32'h0);
    chk(prev_sclk_n == 32 && last_sclk_n == 32, "R4 clocks per frame",
        32'(prev_sclk_n), 32'd32);
    chk(gap_last >= P_GAP * TCK && gap_prev >= P_GAP * TCK, "R5 cs high gap",
        32'(int'(gap_last / TCK)), 32'(P_GAP));
    chk(frames - f0 == 2, "R8 frames per request", 32'(frames - f0), 32'd2);
    cnt = 1;
    @(negedge clk);
    chk(done == 1'b0, "R7 one-cycle done", 32'(done), 32'd0);
    chk(rsp_data == ref_data(k, resp), "R7 result held", 32'(rsp_data),
        32'(ref_data(k, resp)));
    while (busy && cnt < 5000) begin cnt++; @(negedge clk); end
    if (k == 2'd2)
      chk(cnt >= P_HOLD && cnt <= P_HOLD + 3, "R9 write hold", 32'(cnt), 32'(P_HOLD));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10 busy", 32'(busy), 32'd0);
    chk(done == 1'b0, "R10 done", 32'(done), 32'd0);
    chk(spi_cs_n == 1'b1, "R10 cs", 32'(spi_cs_n), 32'd1);
    chk(spi_sclk == 1'b0, "R10 sclk", 32'(spi_sclk), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // directed corners
    txn(2'd0, 8'h00, 16'h0000, 32'h0BFF_FC00, 0);   // R1 rate fetch, negative rate
    txn(2'd1, 8'h0A, 16'h0000, 32'h8C1F_FFE0, 0);   // R2 read, all-ones payload
    txn(2'd1, 8'h0B, 16'h0000, 32'h0012_3460, 0);   // R2 odd address forced even
    txn(2'd2, 8'h12, 16'h03FF, 32'h0000_0000, 0);   // R9 write, no fault
    txn(2'd2, 8'h00, 16'h0000, 32'hE000_0000, 0);   // R3 minimal write word, fault
    txn(2'd2, 8'hFE, 16'hFFFF, 32'h2400_0000, 0);   // R3 dense write word
    txn(2'd3, 8'h55, 16'h1234, 32'h7777_7777, 0);   // R1 kind 3 as rate fetch
    txn(2'd1, 8'h08, 16'h0000, 32'h1234_5678, 1);   // R8 request while busy
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && spi_cs_n == 1'b1, "R8 ignored request left idle",
        32'({busy, spi_cs_n}), 32'b01);
    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 3));
      txn(k, 8'($urandom), 16'($urandom), $urandom, 0);
    end
    finish_run();
  end
endmodule